// File: doc/BRIEF.md
# Write-Back Set-Associative Cache Tag Controller with Bulk Flush

This block keeps the tag-side state of a write-back, write-allocate, set-associative cache: one stored tag, a valid bit and a dirty bit for every line, plus a true least-recently-used order for every set. A client presents a request made of a set index, a tag and a read/write flag. The index comes from address bits. The tag is either the physical tag of the address or a physical page number returned by a separate translation unit. The block answers with hit or miss and the way that now holds the line. When a miss pushes out a dirty line, it reports that line's tag and index so that the data side can write the line back. Data storage and the memory port sit outside this block.

A flush command sweeps every line, one per cycle, in set-major and way-minor order. Each dirty line raises one writeback report. Every line is left invalid and clean, and each set's recency order returns to its reset order. While the sweep runs, `busy` is high and no request is accepted.

The cache geometry comes from size exponents. When the cache is virtually indexed, the associativity exponent is raised to at least the cache-size exponent minus the page-size exponent, so that the set index never reaches past the page offset.

Top module: `cache_wb_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `req_ready` is 1, `resp_valid` and `wb_valid` are 0, every line is invalid, and each set's recency order is way 0 least recent up to way N-1 most recent.
- R2: A request hits only if a valid way of the indexed set holds a tag equal to `req_tag`, and `resp_way` then names that way.
- R3: On a miss, the least recently used way of the set is the victim, and `resp_way` names it. In a set untouched since reset or flush, successive misses fill ways 0, 1, 2, 3 in that order.
- R4: The way that is hit or filled becomes most recently used. Ways that were more recent than it move one step toward least recent, and the rest keep their order.
- R5: A write hit marks the line dirty and reports no writeback. A read miss fills a clean line, and a write miss fills a dirty line.
- R6: A miss whose victim is valid and dirty pulses `wb_valid` in the same cycle as its response, with the victim's old tag on `wb_tag` and the set on `wb_index`. A clean or invalid victim and any hit give no writeback.
- R7: `resp_valid` is a one-cycle pulse in the cycle after each accepted request (`req_valid` and `req_ready` both high at a clock edge), and it is low in every other cycle.
- R8: A flush accepted at edge T holds `busy` high for exactly SETS*WAYS cycles. The line with set s and way w is visited at edge T+1+s*WAYS+w, and if that line is dirty a writeback for it is reported in the following cycle. After the sweep every line is invalid.
- R9: After a flush, each set's recency order is back to its reset order, so misses fill way 0 first again.
- R10: `req_ready` is low while `busy` or `flush_req` is high. A request presented in the same cycle as an accepted flush is not accepted and gets no response.
- R11: With the default parameters (cache exponent 10, block exponent 6, page exponent 8, requested way exponent 1, virtual indexing on), the way exponent is raised to 2. This gives 4 ways and 4 sets, so four distinct tags in one set all stay resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | SET_W | Set index |
| req_tag | input | TAG_W | Physical tag or page number |
| flush_req | input | 1 | Start a full flush (taken when not busy) |
| busy | output | 1 | Flush sweep in progress |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Response was a hit |
| resp_way | output | WAY_W | Way hit or filled |
| wb_valid | output | 1 | Dirty line must be written back |
| wb_index | output | SET_W | Set of the written-back line |
| wb_tag | output | TAG_W | Tag of the written-back line |

## Verification
A request's response and any eviction writeback are registered at the edge that accepts the request. They can be read in the next cycle, so the bench drives requests on the falling edge and reads the outputs one falling edge later. That is also the point where it presents the next request. During a flush, the report for line i is due one cycle after the edge that visits it, which is the (i+1)-th edge after the accepting edge. The bench compares one line per cycle against its model in the same walk order. Once the sweep ends, the bench checks that `busy` has dropped.

// File: rtl/cache_wb_pkg.sv
package cache_wb_pkg;

  typedef enum logic [0:0] {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweep_state_e;

  // Associativity floor for a virtually indexed array: the index bits must
  // stay inside the page offset.
  function automatic int eff_way_log(input int req_log, input int cache_log,
                                     input int page_log, input bit virt_idx);
    if (virt_idx && (req_log < cache_log - page_log))
      return cache_log - page_log;
    return req_log;
  endfunction

endpackage

// File: rtl/cache_lru_ranks.sv
module cache_lru_ranks #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int SET_W = 2,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] victim_way,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic             clr_en,
  input  logic [SET_W-1:0] clr_set
);

  localparam logic [WAY_W-1:0] TOP_RANK = WAY_W'(WAYS - 1);

  // rank 0 = least recent, WAYS-1 = most recent
  logic [WAY_W-1:0] rank_q [SETS][WAYS];
  logic [WAY_W-1:0] touched_rank;

  assign touched_rank = rank_q[touch_set][touch_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          rank_q[s][w] <= WAY_W'(w);
    end else if (clr_en) begin
      for (int w = 0; w < WAYS; w++)
        rank_q[clr_set][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          rank_q[touch_set][w] <= TOP_RANK;
        else if (rank_q[touch_set][w] > touched_rank)
          rank_q[touch_set][w] <= rank_q[touch_set][w] - 1'b1;
      end
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (rank_q[rd_set][w] == '0)
        victim_way = WAY_W'(w);
  end

endmodule

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int TAG_W = 8
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);

  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = way_valid[g] && (way_tags[g] == tag);
  end

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w])
        hit_way = WAY_W'(w);
  end

endmodule

// File: rtl/cache_flush_seq.sv
module cache_flush_seq
  import cache_wb_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SET_W = 2,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [SET_W-1:0] line_set,
  output logic [WAY_W-1:0] line_way,
  output logic             set_done
);

  localparam int               LINE_W    = SET_W + WAY_W;
  localparam logic [LINE_W-1:0] LAST_LINE = '1;

  sweep_state_e      state_q;
  logic [LINE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SWEEP_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SWEEP_IDLE: if (start) begin
          state_q <= SWEEP_RUN;
          cnt_q   <= '0;
        end
        SWEEP_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_LINE)
            state_q <= SWEEP_IDLE;
        end
        default: state_q <= SWEEP_IDLE;
      endcase
    end
  end

  assign busy     = (state_q == SWEEP_RUN);
  assign line_set = cnt_q[LINE_W-1:WAY_W];
  assign line_way = cnt_q[WAY_W-1:0];
  assign set_done = busy && (line_way == WAY_W'(WAYS - 1));

endmodule

// File: rtl/cache_wb_ctrl.sv
module cache_wb_ctrl
  import cache_wb_pkg::*;
#(
  parameter int TAG_W       = 8,
  parameter int CACHE_LOG   = 10,
  parameter int BLOCK_LOG   = 6,
  parameter int WAY_LOG_REQ = 1,
  parameter int PAGE_LOG    = 8,
  parameter bit VIRT_INDEX  = 1'b1,
  localparam int WAY_W = eff_way_log(WAY_LOG_REQ, CACHE_LOG, PAGE_LOG, VIRT_INDEX),
  localparam int SET_W = CACHE_LOG - BLOCK_LOG - WAY_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [SET_W-1:0] req_index,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             flush_req,
  output logic             busy,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [WAY_W-1:0] resp_way,
  output logic             wb_valid,
  output logic [SET_W-1:0] wb_index,
  output logic [TAG_W-1:0] wb_tag
);

  localparam int WAYS   = 1 << WAY_W;
  localparam int SETS   = 1 << SET_W;
  localparam int LINE_W = SET_W + WAY_W;
  localparam int LINES  = SETS * WAYS;

  // ---------------- state storage ----------------
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];

  // ---------------- control ----------------
  logic             accept, flush_start;
  logic             sweep_busy, set_done;
  logic [SET_W-1:0] line_set;
  logic [WAY_W-1:0] line_way;
  logic             hit;
  logic [WAY_W-1:0] hit_way, victim_way, fill_way;
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [TAG_W-1:0] victim_tag, sweep_tag;
  logic             victim_dirty, sweep_dirty;

  assign req_ready   = !sweep_busy && !flush_req;
  assign accept      = req_valid && req_ready;
  assign flush_start = flush_req && !sweep_busy;
  assign busy        = sweep_busy;

  for (genvar g = 0; g < WAYS; g++) begin : g_rd
    assign set_tags[g] = tag_mem[{req_index, WAY_W'(g)}];
  end

  cache_tag_match #(
    .WAYS (WAYS),
    .WAY_W(WAY_W),
    .TAG_W(TAG_W)
  ) u_match (
    .way_tags (set_tags),
    .way_valid(valid_q[req_index]),
    .tag      (req_tag),
    .hit      (hit),
    .hit_way  (hit_way)
  );

  cache_lru_ranks #(
    .SETS (SETS),
    .WAYS (WAYS),
    .SET_W(SET_W),
    .WAY_W(WAY_W)
  ) u_lru (
    .clk       (clk),
    .rst       (rst),
    .rd_set    (req_index),
    .victim_way(victim_way),
    .touch_en  (accept),
    .touch_set (req_index),
    .touch_way (fill_way),
    .clr_en    (set_done),
    .clr_set   (line_set)
  );

  cache_flush_seq #(
    .WAYS (WAYS),
    .SET_W(SET_W),
    .WAY_W(WAY_W)
  ) u_sweep (
    .clk     (clk),
    .rst     (rst),
    .start   (flush_start),
    .busy    (sweep_busy),
    .line_set(line_set),
    .line_way(line_way),
    .set_done(set_done)
  );

  assign fill_way     = hit ? hit_way : victim_way;
  assign victim_tag   = tag_mem[{req_index, victim_way}];
  assign victim_dirty = valid_q[req_index][victim_way] && dirty_q[req_index][victim_way];
  assign sweep_tag    = tag_mem[LINE_W'({line_set, line_way})];
  assign sweep_dirty  = valid_q[line_set][line_way] && dirty_q[line_set][line_way];

  // tag array: write-only port, no reset, so it maps onto RAM
  always_ff @(posedge clk) begin
    if (accept && !hit)
      tag_mem[{req_index, victim_way}] <= req_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (sweep_busy) begin
      valid_q[line_set][line_way] <= 1'b0;
      dirty_q[line_set][line_way] <= 1'b0;
    end else if (accept) begin
      if (hit) begin
        if (req_write)
          dirty_q[req_index][hit_way] <= 1'b1;
      end else begin
        valid_q[req_index][victim_way] <= 1'b1;
        dirty_q[req_index][victim_way] <= req_write;
      end
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_way   <= '0;
      wb_valid   <= 1'b0;
      wb_index   <= '0;
      wb_tag     <= '0;
    end else begin
      resp_valid <= accept;
      resp_hit   <= accept && hit;
      resp_way   <= fill_way;
      if (sweep_busy) begin
        wb_valid <= sweep_dirty;
        wb_index <= line_set;
        wb_tag   <= sweep_tag;
      end else begin
        wb_valid <= accept && !hit && victim_dirty;
        wb_index <= req_index;
        wb_tag   <= victim_tag;
      end
    end
  end

endmodule

// File: rtl/cache_wb_ctrl_chk.sv
module cache_wb_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic flush_req,
  input logic busy,
  input logic resp_valid,
  input logic resp_hit,
  input logic wb_valid
);

  // R7
  resp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> resp_valid);

  // R7
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !resp_valid);

  // R2
  hit_needs_resp_chk: assert property (@(posedge clk) disable iff (rst)
    resp_hit |-> resp_valid);

  // R6
  hit_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> !wb_valid);

  // R8
  flush_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !busy) |=> busy);

  // R10
  busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  // R10
  flush_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> !req_ready);

endmodule

bind cache_wb_ctrl cache_wb_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .flush_req (flush_req),
  .busy      (busy),
  .resp_valid(resp_valid),
  .resp_hit  (resp_hit),
  .wb_valid  (wb_valid)
);

// File: tb/cache_wb_ctrl_tb.sv
module cache_wb_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int M_WAYS = 4;   // R11: effective geometry with defaults
  localparam int M_SETS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0, flush_req = 1'b0;
  logic [1:0] req_index = '0;
  logic [7:0] req_tag = '0;
  logic       req_ready, busy, resp_valid, resp_hit, wb_valid;
  logic [1:0] resp_way, wb_index;
  logic [7:0] wb_tag;

  int checks = 0;
  int errors = 0;

  int m_tag   [M_SETS][M_WAYS];
  bit m_val   [M_SETS][M_WAYS];
  bit m_dirty [M_SETS][M_WAYS];
  int m_rank  [M_SETS][M_WAYS];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_wb_ctrl u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_index(req_index), .req_tag(req_tag),
    .flush_req(flush_req), .busy(busy),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .wb_valid(wb_valid), .wb_index(wb_index), .wb_tag(wb_tag)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic model_order_reset();
    for (int s = 0; s < M_SETS; s++)
      for (int w = 0; w < M_WAYS; w++) m_rank[s][w] = w;
  endtask

  task automatic model_access(input bit wr, input int idx, input int tg,
                              output bit hit, output int way,
                              output bit wb, output int wbtag);
    int r;
    hit = 0; way = 0; wb = 0; wbtag = 0;
    for (int w = 0; w < M_WAYS; w++)
      if (m_val[idx][w] && m_tag[idx][w] == tg) begin hit = 1; way = w; end
    if (hit) begin
      if (wr) m_dirty[idx][way] = 1;
    end else begin
      for (int w = 0; w < M_WAYS; w++) if (m_rank[idx][w] == 0) way = w;
      wb    = m_val[idx][way] && m_dirty[idx][way];
      wbtag = m_tag[idx][way];
      m_val[idx][way] = 1; m_dirty[idx][way] = wr; m_tag[idx][way] = tg;
    end
    r = m_rank[idx][way];
    for (int w = 0; w < M_WAYS; w++)
      if (m_rank[idx][w] > r) m_rank[idx][w]--;
    m_rank[idx][way] = M_WAYS - 1;
  endtask

  // called at a falling edge; returns at the falling edge with outputs checked
  task automatic do_req(input bit wr, input int idx, input int tg);
    bit eh, ewb; int eway, etag;
    req_valid = 1; req_write = wr; req_index = 2'(idx); req_tag = 8'(tg);
    model_access(wr, idx, tg, eh, eway, ewb, etag);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R7 resp_valid pulse", resp_valid, 1);
    chk("R2 hit/miss", resp_hit, eh);
    chk("R3 R4 resp_way", resp_way, eway);
    chk("R5 R6 wb_valid", wb_valid, ewb);
    if (ewb) begin
      chk("R6 wb_tag", wb_tag, etag);
      chk("R6 wb_index", wb_index, idx);
    end
  endtask

  task automatic idle_check();
    @(posedge clk); @(negedge clk);
    chk("R7 resp_valid idle", resp_valid, 0);
    chk("R7 wb_valid idle", wb_valid, 0);
  endtask

  task automatic do_flush(input bit with_req);
    flush_req = 1;
    if (with_req) begin
      req_valid = 1; req_write = 1; req_index = 2'd0; req_tag = 8'd99;
    end
    #1;
    chk("R10 ready low with flush_req", req_ready, 0);
    @(posedge clk); @(negedge clk);
    flush_req = 0; req_valid = 0;
    chk("R10 request beside flush ignored", resp_valid, 0);
    for (int i = 0; i < M_SETS * M_WAYS; i++) begin
      int s, w;
      s = i / M_WAYS; w = i % M_WAYS;
      chk("R8 busy during sweep", busy, 1);
      chk("R10 ready low while busy", req_ready, 0);
      @(posedge clk); @(negedge clk);
      chk("R8 sweep wb_valid", wb_valid, m_val[s][w] && m_dirty[s][w]);
      if (m_val[s][w] && m_dirty[s][w]) begin
        chk("R8 sweep wb_tag", wb_tag, m_tag[s][w]);
        chk("R8 sweep wb_index", wb_index, s);
      end
      m_val[s][w] = 0; m_dirty[s][w] = 0;
    end
    chk("R8 busy drops after sweep", busy, 0);
    chk("R8 ready back", req_ready, 1);
    model_order_reset();  // R9
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < M_SETS; s++)
      for (int w = 0; w < M_WAYS; w++) begin
        m_val[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0;
      end
    model_order_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 wb_valid", wb_valid, 0);

    // R1 R3 R11: four tags in one set fill ways 0..3, all stay resident
    for (int t = 0; t < 4; t++) begin
      do_req(0, 1, 10 + t);
      chk("R3 fill order", resp_way, t);
    end
    for (int t = 0; t < 4; t++) begin
      do_req(0, 1, 10 + t);
      chk("R11 four ways resident", resp_hit, 1);
    end
    idle_check();  // R7
    // R4: refresh 10, then a miss must evict 11 (way 1)
    do_req(0, 1, 10);
    do_req(0, 1, 20);
    chk("R4 victim after touch", resp_way, 1);

    // R5 R6: dirty fill evicted later, clean victims give no wb
    do_req(1, 2, 30);
    do_req(0, 2, 31);
    do_req(0, 2, 32);
    do_req(0, 2, 33);
    do_req(0, 2, 34);
    chk("R6 dirty eviction wb", wb_valid, 1);
    chk("R6 evicted tag", wb_tag, 30);
    do_req(1, 2, 31);
    chk("R5 write hit no wb", wb_valid, 0);

    // random traffic
    for (int n = 0; n < 400; n++)
      do_req(1'($urandom_range(1)), $urandom_range(3), $urandom_range(7));

    // R8 R10 flush with a colliding request, then R9 fill order restarts
    do_flush(1);
    for (int t = 0; t < 4; t++) begin
      do_req(0, 0, 50 + t);
      chk("R9 fill order after flush", resp_way, t);
      chk("R9 miss after flush", resp_hit, 0);
    end

    for (int n = 0; n < 300; n++)
      do_req(1'($urandom_range(1)), $urandom_range(3), $urandom_range(5));
    do_flush(0);
    idle_check();
    for (int n = 0; n < 100; n++)
      do_req(1'($urandom_range(1)), $urandom_range(3), $urandom_range(9));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule